// File: doc/BRIEF.md
# Dual-Target Bus Address Matcher

This block decides, for each address byte received on the bus, whether the byte selects the main target, the recovery (virtual) target, both, or neither. Each target has a static address and a dynamic address, and each address has its own valid flag. A valid dynamic address takes priority: while it is valid, the static address of that target is no longer answered. If neither flag is set, the target does not answer at all. The main target and the virtual target apply this rule independently. Both are compared on every strobe.

When the virtual target matches, the block raises a select that steers the data path to the recovery logic. It also drops the enable for the transfer-queue interrupts. The result of each compare is registered on the clock edge that samples the address strobe, and it holds until the next strobe. The block also produces the address that the main target uses for in-band interrupts, using the same dynamic-over-static priority. A pending interrupt request is masked whenever that address is not valid.

Top module: `tgt_addr_match`

## Requirements
- R1: With a target's dynamic valid flag set, that target matches only when the received address equals its dynamic address. Its static address never produces a match.
- R2: With a target's dynamic valid flag clear and its static valid flag set, the target matches when the received address equals its static address.
- R3: With both valid flags of a target clear, that target never matches.
- R4: The virtual target follows R1 to R3 using its own address pair and flags. Both targets are compared on the same strobe, so one address can assert both match flags.
- R5: The match outputs, the select, the interrupt gate and the read/write output update on the clock edge where `addr_stb_i` is high. They hold their values on every other edge. While in reset, the match outputs and the select are 0, `rnw_o` is 0 and `queue_irq_en_o` is 1.
- R6: `virt_sel_o` is 1 exactly when the registered virtual match is 1. `queue_irq_en_o` is its inverse.
- R7: The received byte `rx_byte_i` holds the address in bits [7:1] and the read/write flag in bit 0. Only bits [7:1] are compared. Bit 0 is registered to `rnw_o` and has no effect on either match.
- R8: `ibi_addr_o` equals the main dynamic address when the main dynamic valid flag is set, and the main static address otherwise. This output is combinational.
- R9: `ibi_addr_vld_o` is 1 when either main valid flag is set. This output is combinational.
- R10: `ibi_pend_o` equals `ibi_req_i` AND `ibi_addr_vld_o`, so a request is masked while the interrupt address is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_stb_i | input | 1 | Received address byte is valid this cycle |
| rx_byte_i | input | 8 | Address in [7:1], read/write flag in [0] |
| main_sta_addr_i | input | 7 | Main target static address |
| main_sta_vld_i | input | 1 | Main static address valid |
| main_dyn_addr_i | input | 7 | Main target dynamic address |
| main_dyn_vld_i | input | 1 | Main dynamic address valid |
| virt_sta_addr_i | input | 7 | Virtual target static address |
| virt_sta_vld_i | input | 1 | Virtual static address valid |
| virt_dyn_addr_i | input | 7 | Virtual target dynamic address |
| virt_dyn_vld_i | input | 1 | Virtual dynamic address valid |
| ibi_req_i | input | 1 | In-band interrupt request from the queue logic |
| main_match_o | output | 1 | Main target was addressed (registered) |
| virt_match_o | output | 1 | Virtual target was addressed (registered) |
| virt_sel_o | output | 1 | Route data path to the recovery logic |
| queue_irq_en_o | output | 1 | Transfer-queue interrupt enable, low while virtual is selected |
| rnw_o | output | 1 | Registered read/write flag of the last strobed byte |
| ibi_addr_o | output | 7 | Address used for in-band interrupts |
| ibi_addr_vld_o | output | 1 | Interrupt address valid |
| ibi_pend_o | output | 1 | Interrupt request after masking |

## Verification
The bench biases received addresses toward the static and dynamic addresses of both targets and drives every combination of valid flags. It also makes one target's static address equal the other target's dynamic address, so a design that lets a valid dynamic address leave the static one active would report a spurious match. A design that applies one target's flags to the other, or that picks only one target when both match, would give the wrong match pair.

Cycles without a strobe check that the registered results hold rather than follow the inputs. A random read/write bit would expose a compare that includes bit 0. With all main flags clear, requests are driven to confirm that the pending output stays low.

// File: rtl/tam_pkg.sv
package tam_pkg;

    // Registered result of one address compare
    typedef struct packed {
        logic main_hit;
        logic virt_hit;
        logic rnw;
    } match_st_t;

    // Index of each target in the per-target arrays
    localparam int unsigned TGT_MAIN = 0;
    localparam int unsigned TGT_VIRT = 1;
    localparam int unsigned NUM_TGT  = 2;

endpackage

// File: rtl/tam_tgt_match.sv
module tam_tgt_match #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [ADDR_W-1:0] sta_addr_i,
    input  logic              sta_vld_i,
    input  logic [ADDR_W-1:0] dyn_addr_i,
    input  logic              dyn_vld_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output logic              eff_vld_o,
    output logic              hit_o
);

    // Dynamic address wins outright; static only counts without it
    always_comb begin
        eff_addr_o = dyn_vld_i ? dyn_addr_i : sta_addr_i;
        eff_vld_o  = dyn_vld_i | sta_vld_i;
        hit_o      = eff_vld_o && (rx_addr_i == eff_addr_o);
    end

endmodule

// File: rtl/tam_ibi_gate.sv
module tam_ibi_gate #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] main_eff_addr_i,
    input  logic              main_eff_vld_i,
    input  logic              ibi_req_i,
    output logic [ADDR_W-1:0] ibi_addr_o,
    output logic              ibi_addr_vld_o,
    output logic              ibi_pend_o
);

    always_comb begin
        ibi_addr_o     = main_eff_addr_i;
        ibi_addr_vld_o = main_eff_vld_i;
        ibi_pend_o     = ibi_req_i & main_eff_vld_i;
    end

endmodule

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
    import tam_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned BYTE_W = ADDR_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              addr_stb_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  logic [ADDR_W-1:0] main_sta_addr_i,
    input  logic              main_sta_vld_i,
    input  logic [ADDR_W-1:0] main_dyn_addr_i,
    input  logic              main_dyn_vld_i,
    input  logic [ADDR_W-1:0] virt_sta_addr_i,
    input  logic              virt_sta_vld_i,
    input  logic [ADDR_W-1:0] virt_dyn_addr_i,
    input  logic              virt_dyn_vld_i,
    input  logic              ibi_req_i,
    output logic              main_match_o,
    output logic              virt_match_o,
    output logic              virt_sel_o,
    output logic              queue_irq_en_o,
    output logic              rnw_o,
    output logic [ADDR_W-1:0] ibi_addr_o,
    output logic              ibi_addr_vld_o,
    output logic              ibi_pend_o
);

    // Address field sits above the read/write bit
    logic [ADDR_W-1:0] rx_addr;
    assign rx_addr = rx_byte_i[BYTE_W-1:1];

    // Per-target configuration gathered into arrays
    logic [ADDR_W-1:0] cfg_sta_addr [NUM_TGT];
    logic [ADDR_W-1:0] cfg_dyn_addr [NUM_TGT];
    logic [NUM_TGT-1:0] cfg_sta_vld;
    logic [NUM_TGT-1:0] cfg_dyn_vld;

    assign cfg_sta_addr[TGT_MAIN] = main_sta_addr_i;
    assign cfg_dyn_addr[TGT_MAIN] = main_dyn_addr_i;
    assign cfg_sta_vld[TGT_MAIN]  = main_sta_vld_i;
    assign cfg_dyn_vld[TGT_MAIN]  = main_dyn_vld_i;
    assign cfg_sta_addr[TGT_VIRT] = virt_sta_addr_i;
    assign cfg_dyn_addr[TGT_VIRT] = virt_dyn_addr_i;
    assign cfg_sta_vld[TGT_VIRT]  = virt_sta_vld_i;
    assign cfg_dyn_vld[TGT_VIRT]  = virt_dyn_vld_i;

    logic [ADDR_W-1:0]  tgt_eff_addr [NUM_TGT];
    logic [NUM_TGT-1:0] tgt_eff_vld;
    logic [NUM_TGT-1:0] tgt_hit;

    // One comparator per target, all evaluated in parallel
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        tam_tgt_match #(.ADDR_W(ADDR_W)) u_match (
            .rx_addr_i  (rx_addr),
            .sta_addr_i (cfg_sta_addr[g]),
            .sta_vld_i  (cfg_sta_vld[g]),
            .dyn_addr_i (cfg_dyn_addr[g]),
            .dyn_vld_i  (cfg_dyn_vld[g]),
            .eff_addr_o (tgt_eff_addr[g]),
            .eff_vld_o  (tgt_eff_vld[g]),
            .hit_o      (tgt_hit[g])
        );
    end

    // Interrupt address follows the main target's effective address
    tam_ibi_gate #(.ADDR_W(ADDR_W)) u_ibi (
        .main_eff_addr_i (tgt_eff_addr[TGT_MAIN]),
        .main_eff_vld_i  (tgt_eff_vld[TGT_MAIN]),
        .ibi_req_i       (ibi_req_i),
        .ibi_addr_o      (ibi_addr_o),
        .ibi_addr_vld_o  (ibi_addr_vld_o),
        .ibi_pend_o      (ibi_pend_o)
    );

    // Two-process state: result captured on strobe, held otherwise
    match_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_stb_i) begin
            st_d.main_hit = tgt_hit[TGT_MAIN];
            st_d.virt_hit = tgt_hit[TGT_VIRT];
            st_d.rnw      = rx_byte_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_match_o   = st_q.main_hit;
    assign virt_match_o   = st_q.virt_hit;
    assign virt_sel_o     = st_q.virt_hit;
    assign queue_irq_en_o = ~st_q.virt_hit;
    assign rnw_o          = st_q.rnw;

    // R1: a valid dynamic address blocks a static-only hit
    a_r1_dyn_blocks_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i && main_dyn_vld_i && (rx_addr != main_dyn_addr_i) |=> !main_match_o);

    // R2: static address answers when dynamic is absent
    a_r2_static_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i && !main_dyn_vld_i && main_sta_vld_i && (rx_addr == main_sta_addr_i)
        |=> main_match_o);

    // R3: no valid address, no match
    a_r3_no_valid_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i && !main_sta_vld_i && !main_dyn_vld_i |=> !main_match_o);

    // R4: virtual target uses its own effective address
    a_r4_virt_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i && (!tgt_eff_vld[TGT_VIRT] || rx_addr != tgt_eff_addr[TGT_VIRT])
        |=> !virt_match_o);

    // R5: results hold between strobes
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_stb_i |=> $stable(main_match_o) && $stable(virt_match_o) && $stable(rnw_o));

    // R6: a virtual hit selects recovery routing and closes the queue gate
    a_r6_virt_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i && virt_dyn_vld_i && (rx_addr == virt_dyn_addr_i)
        |=> virt_sel_o && !queue_irq_en_o);

    // R7: read/write bit is carried through
    a_r7_rnw_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_stb_i |=> rnw_o == $past(rx_byte_i[0]));

    // R8: interrupt address tracks a valid dynamic address
    a_r8_ibi_dyn: assert property (@(posedge clk_i) disable iff (!rst_ni)
        main_dyn_vld_i |-> ibi_addr_o == main_dyn_addr_i);

    // R10: no pending request without a valid interrupt address
    a_r10_ibi_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !main_sta_vld_i && !main_dyn_vld_i |-> !ibi_pend_o);

endmodule

// File: tb/tgt_addr_match_tb.sv
module tgt_addr_match_tb;

    localparam int AW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          stb;
    logic [AW:0]   rx_byte;
    logic [AW-1:0] m_sta, m_dyn, v_sta, v_dyn;
    logic          m_sv, m_dv, v_sv, v_dv, ibi_req;

    logic          main_match, virt_match, virt_sel, q_en, rnw;
    logic [AW-1:0] ibi_addr;
    logic          ibi_vld, ibi_pend;

    tgt_addr_match #(.ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .addr_stb_i(stb), .rx_byte_i(rx_byte),
        .main_sta_addr_i(m_sta), .main_sta_vld_i(m_sv),
        .main_dyn_addr_i(m_dyn), .main_dyn_vld_i(m_dv),
        .virt_sta_addr_i(v_sta), .virt_sta_vld_i(v_sv),
        .virt_dyn_addr_i(v_dyn), .virt_dyn_vld_i(v_dv),
        .ibi_req_i(ibi_req),
        .main_match_o(main_match), .virt_match_o(virt_match),
        .virt_sel_o(virt_sel), .queue_irq_en_o(q_en), .rnw_o(rnw),
        .ibi_addr_o(ibi_addr), .ibi_addr_vld_o(ibi_vld), .ibi_pend_o(ibi_pend)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model: behavioural expected values
    logic  e_main, e_virt, e_rnw;
    string e_mtag, e_vtag;

    function automatic logic ref_hit(logic [AW-1:0] rx, logic [AW-1:0] sa, logic sv,
                                     logic [AW-1:0] da, logic dv);
        if (dv) return rx == da;
        if (sv) return rx == sa;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_main <= 1'b0; e_virt <= 1'b0; e_rnw <= 1'b0;
            e_mtag <= "R5"; e_vtag <= "R5";
        end else if (stb) begin
            e_main <= ref_hit(rx_byte[AW:1], m_sta, m_sv, m_dyn, m_dv);
            e_virt <= ref_hit(rx_byte[AW:1], v_sta, v_sv, v_dyn, v_dv);
            e_rnw  <= rx_byte[0];
            e_mtag <= m_dv ? "R1" : (m_sv ? "R2" : "R3");
            e_vtag <= "R4";
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk(e_mtag, 32'(main_match), 32'(e_main));
        chk(e_vtag, 32'(virt_match), 32'(e_virt));
        chk("R6", 32'(virt_sel), 32'(e_virt));
        chk("R6", 32'(q_en), 32'(!e_virt));
        chk("R7", 32'(rnw), 32'(e_rnw));
        chk("R8", 32'(ibi_addr), 32'(m_dv ? m_dyn : m_sta));
        chk("R9", 32'(ibi_vld), 32'(m_sv | m_dv));
        chk("R10", 32'(ibi_pend), 32'(ibi_req & (m_sv | m_dv)));
    endtask

    task automatic drive_random();
        int pick;
        m_sta = AW'($urandom); m_dyn = AW'($urandom);
        v_sta = AW'($urandom); v_dyn = AW'($urandom);
        if ($urandom_range(0, 3) == 0) v_sta = m_dyn;
        if ($urandom_range(0, 3) == 0) m_sta = v_dyn;
        m_sv = 1'($urandom); m_dv = 1'($urandom);
        v_sv = 1'($urandom); v_dv = 1'($urandom);
        ibi_req = 1'($urandom);
        stb = ($urandom_range(0, 3) != 0);
        pick = $urandom_range(0, 4);
        case (pick)
            0: rx_byte[AW:1] = m_sta;
            1: rx_byte[AW:1] = m_dyn;
            2: rx_byte[AW:1] = v_sta;
            3: rx_byte[AW:1] = v_dyn;
            default: rx_byte[AW:1] = AW'($urandom);
        endcase
        rx_byte[0] = 1'($urandom);
    endtask

    initial begin
        stb = 0; rx_byte = '0; m_sta = 7'h12; m_dyn = 7'h34; v_sta = 7'h56; v_dyn = 7'h78;
        m_sv = 0; m_dv = 0; v_sv = 0; v_dv = 0; ibi_req = 1;
        repeat (3) @(negedge clk);
        // R5 reset state, R10 masking with no valid address
        chk("R5", 32'(main_match), 0);
        chk("R5", 32'(virt_match), 0);
        chk("R5", 32'(q_en), 1);
        chk("R10", 32'(ibi_pend), 0);
        rst_n = 1'b1;

        // R1: static address presented while dynamic valid must miss
        m_sv = 1; m_dv = 1; stb = 1; rx_byte = {7'h12, 1'b1};
        @(negedge clk);
        chk("R1", 32'(main_match), 0);
        chk("R7", 32'(rnw), 1);
        check_all();
        // R4: same address hits both targets in parallel
        v_dv = 1; v_dyn = 7'h34; rx_byte = {7'h34, 1'b0};
        @(negedge clk);
        chk("R4", 32'(main_match), 1);
        chk("R4", 32'(virt_match), 1);
        chk("R6", 32'(q_en), 0);
        // R5: no strobe, inputs change, outputs hold
        stb = 0; rx_byte = {7'h00, 1'b1}; m_dv = 0; v_dv = 0;
        @(negedge clk);
        chk("R5", 32'(main_match), 1);
        chk("R5", 32'(virt_match), 1);
        chk("R5", 32'(rnw), 0);
        check_all();

        for (int i = 0; i < 4000; i++) begin
            drive_random();
            @(negedge clk);
            check_all();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule